// File: doc/BRIEF.md
# Windowless Watchdog Timer with Pretimeout

This block is a bus-mapped watchdog. It has a 16-bit register port and counts down on a slow tick-enable input, nominally 2 Hz. Software sets a timeout field and an enable bit in the control register. It then keeps the system alive by writing a two-word key to the service register. If the count runs out, the block records a timeout cause and pulses a one-cycle reset request to the system reset controller.

An optional early-warning stage raises a level interrupt a programmable number of ticks before the count runs out. A write of 1 to its status bit clears it. The enable bit and the early-warning configuration are write-once until a hardware reset, so a runaway program cannot disable protection. A software-reset bit in the control register gives software a direct way to request a reset, and the block records that cause too.

Top module: `wdog_pretimeout`

## Requirements
- R1: With the control enable bit (bit 2) set, a nonzero timeout field T (control bits 15:8) gives an expiry on tick number T+1 after the counter is loaded. After an expiry the counter reloads T+1 and keeps counting.
- R2: The counter decrements only while enable is 1 and T is nonzero. Every control write reloads the counter with the newly written T+1.
- R3: A service-register write of 0xAAAA that directly follows a service-register write of 0x5555 reloads a running counter with T+1.
- R4: If any other value is written to the service register between 0x5555 and 0xAAAA, the 0xAAAA does not service the watchdog.
- R5: On expiry, bit 1 (timeout cause) of the status register at offset 0x4 becomes 1, and reset_req_o pulses high for exactly one clock.
- R6: A control write with bit 4 at 0 sets bit 0 (software cause) of the status register and pulses reset_req_o. Bit 4 always reads back as 1.
- R7: A control write also pulses reset_req_o at once in two cases. The first is when the write has both bit 5 and bit 4 at 0. The second is when the write leaves enable at 1 with T equal to 0. A write with bit 4 at 1 and bit 5 at 0, enable 0, requests nothing.
- R8: Once enable has been written to 1, later control writes cannot clear it until hardware reset.
- R9: The early warning is armed by a control write, a valid service or an interrupt-control write, and only when the counter is running, the interrupt-enable bit (bit 15 at offset 0x6) is 1 and the loaded count C is greater than the warning value P (bits 7:0). It then fires on the tick that brings the count down to P, which is tick C−P.
- R10: When the warning fires, status bit 14 at offset 0x6 and irq_o go to 1. Writing 1 to bit 14 clears both. The warning does not rearm until the next arming event.
- R11: Only the first interrupt-control write after reset changes bits 15 and 7:0. Later writes only clear bit 14.
- R12: After reset the registers read as follows: control 0x0030, status 0x0000, interrupt control 0x0004, offset 0x8 register 0x0001. irq_o and reset_req_o are both 0.
- R13: The register at offset 0x8 keeps only bit 0. The status register and the service register read as written-only or read-only as stated: writes to status are ignored, and the service register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle countdown tick enable (nominal 2 Hz) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the 16-bit register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| reset_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt, level |

## Verification
The hardest situation to reach from the ports is the early-warning stage under its write-once lock. Arming depends on the order of the interrupt-control and control writes, and on whether the loaded count exceeds the warning value. After the first interrupt-control write, no other configuration can be reached without a hardware reset. Each scenario therefore starts from a fresh reset, writes the configuration first, and then loads the counter through a control write. The ticks are then counted one by one, so that irq_o is sampled on the exact tick where it must rise and on the tick just before it.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam int unsigned TW = 8;   // timeout field width
  localparam int unsigned PW = 8;   // warning value width
  localparam int unsigned TO_LO = 8;
  localparam int unsigned TO_HI = TO_LO + TW - 1;
  localparam int unsigned B_EN  = 2;
  localparam int unsigned B_SRS = 4;
  localparam int unsigned B_WDA = 5;
  localparam int unsigned B_IE  = 15;
  localparam int unsigned B_IS  = 14;

  localparam logic [AW-1:0] A_CTRL = 4'h0;
  localparam logic [AW-1:0] A_SVC  = 4'h2;
  localparam logic [AW-1:0] A_STAT = 4'h4;
  localparam logic [AW-1:0] A_IRQC = 4'h6;
  localparam logic [AW-1:0] A_MISC = 4'h8;

  localparam logic [DW-1:0] KEY_A    = 16'h5555;
  localparam logic [DW-1:0] KEY_B    = 16'hAAAA;
  localparam logic [DW-1:0] CTRL_RST = 16'h0030;
endpackage

// File: rtl/wdp_ctrl_reg.sv
module wdp_ctrl_reg
  import wdp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_q_o,
  output logic          en_d_o,
  output logic [TW-1:0] to_d_o,
  output logic          sw_rst_o,
  output logic          imm_req_o
);
  logic [DW-1:0] ctrl_q, nx;

  always_comb begin
    nx        = wdata_i;
    nx[B_EN]  = wdata_i[B_EN] | ctrl_q[B_EN];  // enable is sticky
    nx[B_SRS] = 1'b1;                          // self-setting
  end

  assign en_d_o    = wr_i ? nx[B_EN] : ctrl_q[B_EN];
  assign to_d_o    = wr_i ? nx[TO_HI:TO_LO] : ctrl_q[TO_HI:TO_LO];
  assign sw_rst_o  = wr_i && !wdata_i[B_SRS];
  assign imm_req_o = wr_i && ((!wdata_i[B_WDA] && !wdata_i[B_SRS]) ||
                              (nx[B_EN] && (nx[TO_HI:TO_LO] == '0)));
  assign ctrl_q_o  = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (wr_i) ctrl_q <= nx;
  end

  assert_en_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[B_EN] |=> ctrl_q[B_EN]);
endmodule

// File: rtl/wdp_key.sv
module wdp_key
  import wdp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          svc_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          kick_o
);
  logic primed_q;

  assign kick_o = svc_wr_i && primed_q && (wdata_i == KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       primed_q <= 1'b0;
    else if (svc_wr_i) primed_q <= (wdata_i == KEY_A);
  end
endmodule

// File: rtl/wdp_counter.sv
module wdp_counter #(
  parameter int unsigned TW = 8,
  parameter int unsigned PW = 8,
  localparam int unsigned CW = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_q_i,
  input  logic          run_d_i,
  input  logic          ctrl_wr_i,
  input  logic          kick_i,
  input  logic          arm_ev_i,
  input  logic [TW-1:0] to_q_i,
  input  logic [TW-1:0] to_d_i,
  input  logic          ie_d_i,
  input  logic [PW-1:0] pre_q_i,
  input  logic [PW-1:0] pre_d_i,
  output logic          expire_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q, cnt_d, load_q, load_d;
  logic          armed_q, armed_d, reload, step;

  assign load_q = {1'b0, to_q_i} + CW'(1);
  assign load_d = {1'b0, to_d_i} + CW'(1);
  assign reload = ctrl_wr_i | (kick_i & run_q_i);
  assign step   = tick_i & run_q_i & !reload;  // a reload absorbs a coinciding tick
  assign expire_o = step && (cnt_q == CW'(1));
  assign fire_o   = step && armed_q && ((cnt_q - CW'(1)) == CW'(pre_q_i));

  always_comb begin
    cnt_d = cnt_q;
    if (ctrl_wr_i)           cnt_d = load_d;
    else if (kick_i && run_q_i) cnt_d = load_q;
    else if (step)           cnt_d = expire_o ? load_q : cnt_q - CW'(1);
    armed_d = armed_q & !fire_o;
    if (reload || arm_ev_i)
      armed_d = run_d_i && ie_d_i && (cnt_d > CW'(pre_d_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CW'(1);
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q_i && !ctrl_wr_i) |=> $stable(cnt_q));
  assert_reload_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && run_q_i && !ctrl_wr_i) |=> (cnt_q == $past(load_q)));
  assert_fire_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !armed_q);
endmodule

// File: rtl/wdp_irq_reg.sv
module wdp_irq_reg #(
  parameter int unsigned PW = 8,
  parameter logic [PW-1:0] PRE_DEF = 8'h04
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          wr_ie_i,
  input  logic          wr_clr_i,
  input  logic [PW-1:0] wr_pre_i,
  input  logic          fire_i,
  output logic          ie_q_o,
  output logic          ie_d_o,
  output logic [PW-1:0] pre_q_o,
  output logic [PW-1:0] pre_d_o,
  output logic          stat_o
);
  logic          lock_q, ie_q, stat_q, cfg_wr;
  logic [PW-1:0] pre_q;

  assign cfg_wr  = wr_i && !lock_q;
  assign ie_d_o  = cfg_wr ? wr_ie_i  : ie_q;
  assign pre_d_o = cfg_wr ? wr_pre_i : pre_q;
  assign ie_q_o  = ie_q;
  assign pre_q_o = pre_q;
  assign stat_o  = stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      ie_q   <= 1'b0;
      pre_q  <= PRE_DEF;
      stat_q <= 1'b0;
    end else begin
      lock_q <= lock_q | wr_i;
      ie_q   <= ie_d_o;
      pre_q  <= pre_d_o;
      if (fire_i)                stat_q <= 1'b1;
      else if (wr_i && wr_clr_i) stat_q <= 1'b0;
    end
  end

  assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(ie_q) && $stable(pre_q)));
  assert_fire_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> stat_q);
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
  import wdp_pkg::*;
#(
  parameter logic [PW-1:0] PRE_DEF = 8'h04
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          reset_req_o,
  output logic          irq_o
);
  logic          ctrl_wr, svc_wr, irqc_wr, misc_wr;
  logic [DW-1:0] ctrl_q;
  logic          en_d, sw_rst, imm_req, kick, expire, fire;
  logic [TW-1:0] to_d;
  logic          run_q, run_d;
  logic          ie_q, ie_d, ist;
  logic [PW-1:0] pre_q, pre_d;
  logic          to_flag_q, sw_flag_q, misc_q, req_q;

  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign svc_wr  = wr_en_i && (addr_i == A_SVC);
  assign irqc_wr = wr_en_i && (addr_i == A_IRQC);
  assign misc_wr = wr_en_i && (addr_i == A_MISC);

  wdp_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .wdata_i,
    .ctrl_q_o(ctrl_q), .en_d_o(en_d), .to_d_o(to_d),
    .sw_rst_o(sw_rst), .imm_req_o(imm_req)
  );

  wdp_key u_key (
    .clk_i, .rst_ni, .svc_wr_i(svc_wr), .wdata_i, .kick_o(kick)
  );

  assign run_q = ctrl_q[B_EN] && (ctrl_q[TO_HI:TO_LO] != '0);
  assign run_d = en_d && (to_d != '0);

  wdp_irq_reg #(.PW(PW), .PRE_DEF(PRE_DEF)) u_irq (
    .clk_i, .rst_ni, .wr_i(irqc_wr),
    .wr_ie_i(wdata_i[B_IE]), .wr_clr_i(wdata_i[B_IS]), .wr_pre_i(wdata_i[PW-1:0]),
    .fire_i(fire), .ie_q_o(ie_q), .ie_d_o(ie_d),
    .pre_q_o(pre_q), .pre_d_o(pre_d), .stat_o(ist)
  );

  wdp_counter #(.TW(TW), .PW(PW)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .run_q_i(run_q), .run_d_i(run_d),
    .ctrl_wr_i(ctrl_wr), .kick_i(kick), .arm_ev_i(irqc_wr),
    .to_q_i(ctrl_q[TO_HI:TO_LO]), .to_d_i(to_d),
    .ie_d_i(ie_d), .pre_q_i(pre_q), .pre_d_i(pre_d),
    .expire_o(expire), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_flag_q <= 1'b0;
      sw_flag_q <= 1'b0;
      misc_q    <= 1'b1;
      req_q     <= 1'b0;
    end else begin
      if (expire)  to_flag_q <= 1'b1;
      if (sw_rst)  sw_flag_q <= 1'b1;
      if (misc_wr) misc_q    <= wdata_i[0];
      req_q <= (expire && ctrl_q[B_EN]) || sw_rst || imm_req;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {{(DW-2){1'b0}}, to_flag_q, sw_flag_q};
      A_IRQC:  rdata_o = {ie_q, ist, {(DW-2-PW){1'b0}}, pre_q};
      A_MISC:  rdata_o = {{(DW-1){1'b0}}, misc_q};
      default: rdata_o = '0;
    endcase
  end

  assign reset_req_o = req_q;
  assign irq_o       = ist;

  assert_expire_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (reset_req_o && to_flag_q));
  assert_sw_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> (sw_flag_q && reset_req_o));
  assert_no_idle_expire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !expire);
endmodule

// File: tb/sim_wdog_pretimeout.sv
module sim_wdog_pretimeout;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req, irq;
  int          n_tests = 0;
  int          n_fail = 0;
  int          pulses = 0;

  always #2.5 clk = ~clk;

  wdog_pretimeout u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .reset_req_o(req), .irq_o(irq)
  );

  always @(posedge clk) if (req) pulses <= pulses + 1;

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd_chk(input string r, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(r, rdata, exp);
  endtask

  task automatic pulse_chk(input string r, input int exp);
    @(negedge clk);
    chk(r, 16'(pulses), 16'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R12 ctrl", 4'h0, 16'h0030);
    rd_chk("R12 stat", 4'h4, 16'h0000);
    rd_chk("R12 irqc", 4'h6, 16'h0004);
    rd_chk("R12 misc", 4'h8, 16'h0001);
    chk("R12 irq", {15'b0, irq}, 16'h0);
    pulse_chk("R12 req", 0);
  endtask

  task automatic t_expiry();
    do_reset();
    wr(4'h0, 16'h0334);
    ticks(3);
    rd_chk("R1 no early expiry", 4'h4, 16'h0000);
    pulse_chk("R1 no early req", 0);
    ticks(1);
    rd_chk("R5 timeout flag", 4'h4, 16'h0002);
    pulse_chk("R5 one pulse", 1);
    ticks(3);
    pulse_chk("R1 reload after expiry", 1);
    ticks(1);
    pulse_chk("R1 second expiry", 2);
  endtask

  task automatic t_idle();
    do_reset();
    wr(4'h0, 16'h0530);
    ticks(10);
    rd_chk("R2 disabled holds", 4'h4, 16'h0000);
    do_reset();
    wr(4'h0, 16'h0234);
    ticks(2);
    wr(4'h0, 16'h0234);
    ticks(2);
    rd_chk("R2 write reloads", 4'h4, 16'h0000);
    ticks(1);
    rd_chk("R2 expiry after reload", 4'h4, 16'h0002);
  endtask

  task automatic t_service();
    do_reset();
    wr(4'h0, 16'h0234);
    ticks(2);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    ticks(2);
    rd_chk("R3 serviced", 4'h4, 16'h0000);
    ticks(1);
    rd_chk("R3 expiry after service", 4'h4, 16'h0002);
  endtask

  task automatic t_broken();
    do_reset();
    wr(4'h0, 16'h0234);
    ticks(2);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    ticks(1);
    rd_chk("R4 broken key no service", 4'h4, 16'h0002);
    pulse_chk("R4 req", 1);
  endtask

  task automatic t_swrst();
    do_reset();
    wr(4'h0, 16'h0020);
    pulse_chk("R6 req", 1);
    rd_chk("R6 sw flag", 4'h4, 16'h0001);
    rd_chk("R6 bit reads 1", 4'h0, 16'h0030);
  endtask

  task automatic t_imm();
    do_reset();
    wr(4'h0, 16'h0034);
    pulse_chk("R7 en with zero timeout", 1);
    rd_chk("R7 no cause flag", 4'h4, 16'h0000);
    do_reset();
    wr(4'h0, 16'h0000);
    pulse_chk("R7 both bits clear", 1);
    do_reset();
    wr(4'h0, 16'h0010);
    pulse_chk("R7 quiet write", 0);
  endtask

  task automatic t_lock();
    do_reset();
    wr(4'h0, 16'h0434);
    wr(4'h0, 16'h0430);
    rd_chk("R8 enable kept", 4'h0, 16'h0434);
    ticks(4);
    rd_chk("R8 still counting", 4'h4, 16'h0000);
    ticks(1);
    rd_chk("R8 expiry", 4'h4, 16'h0002);
  endtask

  task automatic t_pre();
    do_reset();
    wr(4'h6, 16'h8002);
    rd_chk("R11 first write", 4'h6, 16'h8002);
    wr(4'h0, 16'h0534);
    ticks(3);
    chk("R9 not yet", {15'b0, irq}, 16'h0);
    ticks(1);
    chk("R9 fires at C-P", {15'b0, irq}, 16'h1);
    rd_chk("R10 status set", 4'h6, 16'hC002);
    wr(4'h6, 16'h4000);
    chk("R10 cleared", {15'b0, irq}, 16'h0);
    rd_chk("R11 cfg kept", 4'h6, 16'h8002);
    ticks(2);
    rd_chk("R9 expiry follows", 4'h4, 16'h0002);
    chk("R10 no rearm", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_pre_skip();
    do_reset();
    wr(4'h6, 16'h8008);
    wr(4'h0, 16'h0534);
    ticks(6);
    chk("R9 count not above P", {15'b0, irq}, 16'h0);
    rd_chk("R9 expiry", 4'h4, 16'h0002);
    do_reset();
    wr(4'h6, 16'h0002);
    wr(4'h6, 16'h8002);
    rd_chk("R11 second write ignored", 4'h6, 16'h0002);
    wr(4'h0, 16'h0534);
    ticks(6);
    chk("R9 needs enable", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_misc();
    do_reset();
    wr(4'h8, 16'h0000);
    rd_chk("R13 misc clear", 4'h8, 16'h0000);
    wr(4'h8, 16'hFFFF);
    rd_chk("R13 misc bit0 only", 4'h8, 16'h0001);
    wr(4'h4, 16'hFFFF);
    rd_chk("R13 status read-only", 4'h4, 16'h0000);
    wr(4'h2, 16'h5555);
    rd_chk("R13 service reads 0", 4'h2, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog timeout act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_expiry();
    t_idle();
    t_service();
    t_broken();
    t_swrst();
    t_imm();
    t_lock();
    t_pre();
    t_pre_skip();
    t_misc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule